// File: doc/BRIEF.md
# Calendar Clock Core with Coherent Read Snapshot

This core keeps wall-clock time and the calendar: seconds, minutes, hours, date, month, year, day of week and a century byte, all held as packed BCD. A free-running 32.768 kHz enable (`tick_en`) is divided by a parameterised prescaler into one seconds increment. Within a single clock cycle the increment ripples through every field. This covers the minute and hour carries, the choice of month length, the leap-year rule including century years, the carry from year into century, and a day-of-week count that wraps. Bit 7 of the hour register selects the 24-hour format. When that bit is clear, the hour runs 12, 1 … 11 and bit 5 acts as the PM flag.

A host writes any field through a simple address/data strobe. A run state machine holds all counting after a cold reset (`ST_COLD`). The first write to any address, moves it to `ST_RUN` for good. Writing the seconds field also zeroes the prescaler. The host reads through a shadow latch. A `rd_start` pulse copies all eight fields at once and loads the read pointer from `rd_addr`, moving the read state machine from `RD_IDLE` to `RD_BURST`; a `rd_start` in `RD_BURST` restarts the burst. Each `rd_next` pulse advances the pointer, wrapping from 7 to 0. The seventh advance returns the machine to `RD_IDLE`. The live counters continue to advance throughout.

Top module: `cal_clock_core`

## Requirements
- R1: After reset the fields read sec 00, min 00, hour 80 (24-hour, 00), date 01, month 01, year 00, day-of-week 00, century 20. The state is `ST_COLD` and nothing advances, however many ticks arrive, until the first write.
- R2: After a write to any address the clock runs, and the seconds field advances by one for every PRESCALE `tick_en` cycles.
- R3: A write to the seconds field (address 0) restarts the prescaler, so the next increment arrives exactly PRESCALE ticks after that write.
- R4: In 24-hour mode (hour bit 7 = 1, hour in bits 5:0) seconds and minutes wrap 59→00 with a carry, and the hour counts 00→23→00, with midnight at the 23→00 wrap.
- R5: In 12-hour mode (hour bit 7 = 0, BCD hour in bits 4:0, PM in bit 5) the hour runs 12→01→…→11→12. PM toggles only on 11→12, and midnight is 11 PM→12 AM.
- R6: At each midnight the day of week (address 6) advances 0→…→6→0.
- R7: At midnight the date moves to 01 of the next month after day 30 of April, June, September and November, after day 31 of the other months, and after the last day of February. Otherwise it increments by one.
- R8: February has 29 days when century×100+year is a leap year. That is the case when it is divisible by 4, except that years ending in 00 count only when divisible by 400.
- R9: December 31 rolls to January 1 of the next year. Year 99 wraps to 00 and increments the century (address 7).
- R10: `rd_start` copies all fields in that cycle. Later reads return that copy while the live time keeps advancing, and a new `rd_start` returns the advanced time.
- R11: `rd_data` shows the field at the pointer, which `rd_start` loads from `rd_addr`. Each `rd_next` in `RD_BURST` advances it with 7→0 wrap. After seven advances `rd_next` has no effect.
- R12: A write stores `wr_data` unchanged at `wr_addr`. The address map is 0 sec, 1 min, 2 hour, 3 date, 4 month, 5 year, 6 day-of-week, 7 century.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset; models loss of all power |
| tick_en | input | 1 | 32.768 kHz timebase enable, one cycle wide |
| wr_en | input | 1 | Field write strobe |
| wr_addr | input | 3 | Field address for a write |
| wr_data | input | 8 | BCD byte to store |
| rd_start | input | 1 | Capture snapshot and load read pointer |
| rd_addr | input | 3 | Starting field of a read burst |
| rd_next | input | 1 | Advance read pointer |
| rd_data | output | 8 | Snapshot field at the read pointer |

## Verification
A write takes effect at the next edge, and the run state changes at that same edge. The prescaler pulse comes combinationally on the PRESCALE-th tick, so the whole rollover is visible one edge after that tick. A snapshot is taken at the `rd_start` edge. `rd_data` follows the pointer combinationally, so it is valid right after the `rd_start` edge and after each `rd_next` edge. The bench drives on falling edges and samples just before the next drive. It disables ticks while it sets a time and then supplies exactly PRESCALE ticks, so every expected field can be computed arithmetically for the sweeps over hours, weekdays, months and leap years.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int FIELD_W = 8;
    localparam int ADDR_W  = 3;
    localparam int NFIELDS = 1 << ADDR_W;

    typedef enum logic [ADDR_W-1:0] {
        A_SEC   = 3'd0,
        A_MIN   = 3'd1,
        A_HOUR  = 3'd2,
        A_DATE  = 3'd3,
        A_MONTH = 3'd4,
        A_YEAR  = 3'd5,
        A_DOW   = 3'd6,
        A_CENT  = 3'd7
    } field_addr_e;

    typedef enum logic { ST_COLD = 1'b0, ST_RUN = 1'b1 } run_state_e;
    typedef enum logic { RD_IDLE = 1'b0, RD_BURST = 1'b1 } rd_state_e;

    // field order makes address N sit at bits [8N+7:8N]
    typedef struct packed {
        logic [FIELD_W-1:0] cent;
        logic [FIELD_W-1:0] dow;
        logic [FIELD_W-1:0] year;
        logic [FIELD_W-1:0] month;
        logic [FIELD_W-1:0] date;
        logic [FIELD_W-1:0] hour;
        logic [FIELD_W-1:0] min;
        logic [FIELD_W-1:0] sec;
    } cal_time_t;

    function automatic logic [6:0] bcd2bin(input logic [7:0] b);
        return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
    endfunction

    function automatic logic [7:0] bcd_inc(input logic [7:0] b);
        if (b[3:0] >= 4'd9) return {b[7:4] + 4'd1, 4'd0};
        return {b[7:4], b[3:0] + 4'd1};
    endfunction

    function automatic logic is_leap(input logic [7:0] yr, input logic [7:0] ce);
        logic [6:0] y;
        logic [6:0] c;
        y = bcd2bin(yr);
        c = bcd2bin(ce);
        if (y == 7'd0) return (c[1:0] == 2'b00);
        return (y[1:0] == 2'b00);
    endfunction

    function automatic logic [7:0] month_len(input logic [7:0] mon, input logic leap);
        unique case (mon)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
    parameter int PRESCALE = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic clear,
    input  logic tick_en,
    output logic sec_pulse,
    output logic cnt_zero
);
    localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || !enable) begin
            cnt_q <= '0;
        end else if (tick_en) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign sec_pulse = enable && !clear && tick_en && (cnt_q == LAST);
    assign cnt_zero  = (cnt_q == '0);

endmodule

// File: rtl/cal_time_regs.sv
module cal_time_regs
    import cal_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sec_pulse,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [FIELD_W-1:0]   wr_data,
    output cal_time_t            live
);
    cal_time_t cur_q;
    cal_time_t nxt;
    logic       day_roll;
    logic [7:0] dim;
    logic [7:0] hr_inc;

    // one-second advance rippling through every field
    always_comb begin
        nxt      = cur_q;
        day_roll = 1'b0;
        dim      = month_len(cur_q.month, is_leap(cur_q.year, cur_q.cent));
        hr_inc   = cur_q.hour[7] ? bcd_inc({2'b00, cur_q.hour[5:0]})
                                 : bcd_inc({3'b000, cur_q.hour[4:0]});
        if (cur_q.sec == 8'h59) begin
            nxt.sec = 8'h00;
            if (cur_q.min == 8'h59) begin
                nxt.min = 8'h00;
                if (cur_q.hour[7]) begin
                    if (cur_q.hour[5:0] == 6'h23) begin
                        nxt.hour = {cur_q.hour[7:6], 6'h00};
                        day_roll = 1'b1;
                    end else begin
                        nxt.hour = {cur_q.hour[7:6], hr_inc[5:0]};
                    end
                end else begin
                    if (cur_q.hour[4:0] == 5'h12) begin
                        nxt.hour = {cur_q.hour[7:5], 5'h01};
                    end else if (cur_q.hour[4:0] == 5'h11) begin
                        nxt.hour = {cur_q.hour[7:6], ~cur_q.hour[5], 5'h12};
                        day_roll = cur_q.hour[5];
                    end else begin
                        nxt.hour = {cur_q.hour[7:5], hr_inc[4:0]};
                    end
                end
            end else begin
                nxt.min = bcd_inc(cur_q.min);
            end
        end else begin
            nxt.sec = bcd_inc(cur_q.sec);
        end

        if (day_roll) begin
            nxt.dow = (cur_q.dow >= 8'h06) ? 8'h00 : cur_q.dow + 8'h01;
            if (cur_q.date >= dim) begin
                nxt.date = 8'h01;
                if (cur_q.month >= 8'h12) begin
                    nxt.month = 8'h01;
                    if (cur_q.year == 8'h99) begin
                        nxt.year = 8'h00;
                        nxt.cent = (cur_q.cent == 8'h99) ? 8'h00 : bcd_inc(cur_q.cent);
                    end else begin
                        nxt.year = bcd_inc(cur_q.year);
                    end
                end else begin
                    nxt.month = bcd_inc(cur_q.month);
                end
            end else begin
                nxt.date = bcd_inc(cur_q.date);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{cent: 8'h20, dow: 8'h00, year: 8'h00, month: 8'h01,
                       date: 8'h01, hour: 8'h80, min: 8'h00, sec: 8'h00};
        end else if (wr_en) begin
            unique case (field_addr_e'(wr_addr))
                A_SEC:   cur_q.sec   <= wr_data;
                A_MIN:   cur_q.min   <= wr_data;
                A_HOUR:  cur_q.hour  <= wr_data;
                A_DATE:  cur_q.date  <= wr_data;
                A_MONTH: cur_q.month <= wr_data;
                A_YEAR:  cur_q.year  <= wr_data;
                A_DOW:   cur_q.dow   <= wr_data;
                A_CENT:  cur_q.cent  <= wr_data;
            endcase
        end else if (sec_pulse) begin
            cur_q <= nxt;
        end
    end

    assign live = cur_q;

endmodule

// File: rtl/cal_snapshot.sv
module cal_snapshot
    import cal_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_start,
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic               rd_next,
    input  cal_time_t          live,
    output logic [FIELD_W-1:0] rd_data,
    output logic               burst
);
    localparam logic [ADDR_W-1:0] ADVANCES = ADDR_W'(NFIELDS - 1);

    rd_state_e         state_q, state_d;
    cal_time_t         snap_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] left_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE:  if (rd_start) state_d = RD_BURST;
            RD_BURST: if (!rd_start && rd_next && left_q == 1) state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
            ptr_q  <= '0;
            left_q <= '0;
        end else if (rd_start) begin
            snap_q <= live;
            ptr_q  <= rd_addr;
            left_q <= ADVANCES;
        end else if (state_q == RD_BURST && rd_next) begin
            ptr_q  <= ptr_q + 1'b1;
            left_q <= left_q - 1'b1;
        end
    end

    assign rd_data = snap_q[ptr_q*FIELD_W +: FIELD_W];
    assign burst   = (state_q == RD_BURST);

endmodule

// File: rtl/cal_clock_core.sv
module cal_clock_core
    import cal_pkg::*;
#(
    parameter int PRESCALE = 32768
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         wr_en,
    input  logic [2:0]   wr_addr,
    input  logic [7:0]   wr_data,
    input  logic         rd_start,
    input  logic [2:0]   rd_addr,
    input  logic         rd_next,
    output logic [7:0]   rd_data
);
    run_state_e run_q, run_d;
    logic       sec_pulse;
    logic       pre_zero;
    logic       pre_clear;
    logic       rd_burst;
    cal_time_t  live;

    always_comb begin
        run_d = run_q;
        unique case (run_q)
            ST_COLD: if (wr_en) run_d = ST_RUN;
            ST_RUN:  run_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= ST_COLD;
        else        run_q <= run_d;
    end

    assign pre_clear = wr_en && (field_addr_e'(wr_addr) == A_SEC);

    cal_prescaler #(.PRESCALE(PRESCALE)) i_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (run_q == ST_RUN),
        .clear     (pre_clear),
        .tick_en   (tick_en),
        .sec_pulse (sec_pulse),
        .cnt_zero  (pre_zero)
    );

    cal_time_regs i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_pulse (sec_pulse),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .live      (live)
    );

    cal_snapshot i_snap (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_start (rd_start),
        .rd_addr  (rd_addr),
        .rd_next  (rd_next),
        .live     (live),
        .rd_data  (rd_data),
        .burst    (rd_burst)
    );

endmodule

// File: rtl/cal_clock_chk.sv
module cal_clock_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cold,
    input logic       sec_pulse,
    input logic       pre_zero,
    input logic       wr_en,
    input logic [2:0] wr_addr,
    input logic [7:0] live_sec,
    input logic       rd_start,
    input logic [2:0] rd_addr,
    input logic       rd_next,
    input logic       rd_burst,
    input logic [7:0] rd_data
);
    // R1
    cold_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cold && !wr_en) |=> $stable(live_sec));

    // R1
    stay_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cold |=> !cold);

    // R2
    pulse_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |-> !cold);

    // R3
    presc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd0) |=> pre_zero);

    // R4
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && !wr_en && live_sec == 8'h59) |=> (live_sec == 8'h00));

    // R10
    snap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && rd_addr == 3'd0) |=> (rd_data == $past(live_sec)));

    // R11
    idle_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_burst && !rd_start && rd_next) |=> $stable(rd_data));

endmodule

bind cal_clock_core cal_clock_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cold      (run_q == cal_pkg::ST_COLD),
    .sec_pulse (sec_pulse),
    .pre_zero  (pre_zero),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .live_sec  (live.sec),
    .rd_start  (rd_start),
    .rd_addr   (rd_addr),
    .rd_next   (rd_next),
    .rd_burst  (rd_burst),
    .rd_data   (rd_data)
);

// File: tb/test_cal_clock_core.sv
module test_cal_clock_core;

    localparam int CLK_PERIOD = 10;
    localparam int PRE        = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_start = 1'b0;
    logic [2:0] rd_addr = '0;
    logic       rd_next = 1'b0;
    logic [7:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] got [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    cal_clock_core #(.PRESCALE(PRE)) i_cal_clock_core (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_start(rd_start), .rd_addr(rd_addr), .rd_next(rd_next),
        .rd_data(rd_data)
    );

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int mlen(input int m, input int full);
        logic lp;
        lp = (full % 4 == 0) && ((full % 100 != 0) || (full % 400 == 0));
        if (m == 2) return lp ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic start_snap(input int a);
        @(negedge clk);
        rd_start = 1'b1; rd_addr = 3'(a);
        @(negedge clk);
        rd_start = 1'b0;
    endtask

    // reads 8 fields from the pointer onward; got[] indexed by address
    task automatic read_burst(input int a);
        got[a] = rd_data;
        for (int i = 1; i < 8; i++) begin
            rd_next = 1'b1;
            @(negedge clk);
            got[(a + i) % 8] = rd_data;
        end
        rd_next = 1'b0;
    endtask

    task automatic snap_all();
        start_snap(0);
        read_burst(0);
    endtask

    task automatic set_time(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                            input logic [7:0] dt, input logic [7:0] mo, input logic [7:0] y,
                            input logic [7:0] dw, input logic [7:0] c);
        wr(1, mi); wr(2, h); wr(3, dt); wr(4, mo); wr(5, y); wr(6, dw); wr(7, c);
        wr(0, s);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        snap_all();
        check("R1", "sec",   got[0], 8'h00);
        check("R1", "min",   got[1], 8'h00);
        check("R1", "hour",  got[2], 8'h80);
        check("R1", "date",  got[3], 8'h01);
        check("R1", "month", got[4], 8'h01);
        check("R1", "year",  got[5], 8'h00);
        check("R1", "dow",   got[6], 8'h00);
        check("R1", "cent",  got[7], 8'h20);
        // R1 cold: ticks ignored
        ticks(PRE * 6);
        snap_all();
        check("R1", "cold sec", got[0], 8'h00);

        // R2 any write starts the clock
        wr(6, 8'h03);
        ticks(PRE * 5);
        snap_all();
        check("R2", "sec after 5 periods", got[0], 8'h05);
        check("R12", "dow readback", got[6], 8'h03);

        // R3 seconds write restarts prescaler
        ticks(PRE - 1);
        wr(0, 8'h10);
        ticks(PRE - 1);
        snap_all();
        check("R3", "sec before full period", got[0], 8'h10);
        ticks(1);
        snap_all();
        check("R3", "sec after full period", got[0], 8'h11);

        // R12 write readback of every field
        set_time(8'h42, 8'h17, 8'h05, 8'h09, 8'h07, 8'h63, 8'h02, 8'h19);
        snap_all();
        check("R12", "sec",   got[0], 8'h42);
        check("R12", "min",   got[1], 8'h17);
        check("R12", "hour",  got[2], 8'h05);
        check("R12", "date",  got[3], 8'h09);
        check("R12", "month", got[4], 8'h07);
        check("R12", "year",  got[5], 8'h63);
        check("R12", "dow",   got[6], 8'h02);
        check("R12", "cent",  got[7], 8'h19);

        // R4 24-hour sweep
        for (int h = 0; h < 24; h++) begin
            set_time(8'h59, 8'h59, 8'h80 | bcd(h), 8'h10, 8'h03, 8'h21, 8'h01, 8'h20);
            ticks(PRE);
            snap_all();
            check("R4", "sec",  got[0], 8'h00);
            check("R4", "min",  got[1], 8'h00);
            check("R4", "hour", got[2], 8'h80 | bcd((h + 1) % 24));
            check("R4", "date", got[3], (h == 23) ? 8'h11 : 8'h10);
        end
        // R4 minute carry only
        set_time(8'h59, 8'h28, 8'h85, 8'h10, 8'h03, 8'h21, 8'h01, 8'h20);
        ticks(PRE);
        snap_all();
        check("R4", "min carry", got[1], 8'h29);
        check("R4", "hour held", got[2], 8'h85);

        // R5 12-hour sweep
        for (int pm = 0; pm < 2; pm++) begin
            for (int h = 1; h <= 12; h++) begin
                int nh;
                int npm;
                nh  = (h == 12) ? 1 : h + 1;
                npm = (h == 11) ? 1 - pm : pm;
                set_time(8'h59, 8'h59, 8'((pm << 5)) | bcd(h), 8'h10, 8'h03, 8'h21, 8'h01, 8'h20);
                ticks(PRE);
                snap_all();
                check("R5", "hour12", got[2], 8'((npm << 5)) | bcd(nh));
                check("R5", "date12", got[3], (h == 11 && pm == 1) ? 8'h11 : 8'h10);
            end
        end

        // R6 day-of-week sweep
        for (int d = 0; d < 7; d++) begin
            set_time(8'h59, 8'h59, 8'h80 | 8'h23, 8'h10, 8'h03, 8'h21, 8'(d), 8'h20);
            ticks(PRE);
            snap_all();
            check("R6", "dow", got[6], 8'((d + 1) % 7));
        end

        // R7 month lengths in a common year
        for (int m = 1; m <= 12; m++) begin
            int len;
            len = mlen(m, 2001);
            set_time(8'h59, 8'h59, 8'hA3, bcd(len), bcd(m), 8'h01, 8'h00, 8'h20);
            ticks(PRE);
            snap_all();
            check("R7", "date wrap",  got[3], 8'h01);
            check("R7", "month next", got[4], bcd(m % 12 + 1));
            set_time(8'h59, 8'h59, 8'hA3, bcd(len - 1), bcd(m), 8'h01, 8'h00, 8'h20);
            ticks(PRE);
            snap_all();
            check("R7", "date step", got[3], bcd(len));
            check("R7", "month held", got[4], bcd(m));
        end

        // R8 leap rule including century years
        begin
            int cy [6] = '{20, 20, 20, 19, 21, 24};
            int yy [6] = '{24, 23, 0, 0, 0, 0};
            for (int k = 0; k < 6; k++) begin
                int full;
                full = cy[k] * 100 + yy[k];
                set_time(8'h59, 8'h59, 8'hA3, 8'h28, 8'h02, bcd(yy[k]), 8'h00, bcd(cy[k]));
                ticks(PRE);
                snap_all();
                check("R8", "feb28 next", got[3], (mlen(2, full) == 29) ? 8'h29 : 8'h01);
                check("R8", "feb28 month", got[4], (mlen(2, full) == 29) ? 8'h02 : 8'h03);
            end
        end

        // R9 year end and century carry
        set_time(8'h59, 8'h59, 8'hA3, 8'h31, 8'h12, 8'h99, 8'h04, 8'h20);
        ticks(PRE);
        snap_all();
        check("R9", "date", got[3], 8'h01);
        check("R9", "month", got[4], 8'h01);
        check("R9", "year", got[5], 8'h00);
        check("R9", "cent", got[7], 8'h21);
        set_time(8'h59, 8'h59, 8'hA3, 8'h31, 8'h12, 8'h45, 8'h04, 8'h20);
        ticks(PRE);
        snap_all();
        check("R9", "year inc", got[5], 8'h46);
        check("R9", "cent held", got[7], 8'h20);

        // R10 snapshot frozen while live time advances
        set_time(8'h59, 8'h00, 8'h80, 8'h10, 8'h03, 8'h21, 8'h01, 8'h20);
        start_snap(0);
        ticks(PRE);
        read_burst(0);
        check("R10", "frozen sec", got[0], 8'h59);
        check("R10", "frozen min", got[1], 8'h00);
        snap_all();
        check("R10", "live sec", got[0], 8'h00);
        check("R10", "live min", got[1], 8'h01);

        // R11 start pointer, wrap, and idle rd_next
        set_time(8'h30, 8'h31, 8'h82, 8'h13, 8'h04, 8'h35, 8'h06, 8'h37);
        start_snap(5);
        read_burst(5);
        check("R11", "a5", got[5], 8'h35);
        check("R11", "a6", got[6], 8'h06);
        check("R11", "a7", got[7], 8'h37);
        check("R11", "a0 wrap", got[0], 8'h30);
        check("R11", "a4 last", got[4], 8'h04);
        @(negedge clk);
        rd_next = 1'b1;
        @(negedge clk);
        rd_next = 1'b0;
        @(negedge clk);
        check("R11", "idle next ignored", rd_data, 8'h04);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule